// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

A synchronous supervisor that merges three reset causes into one stretched system reset, driven as an active-high output and as its active-low complement. The three causes are a supply-good status input, an active-low manual reset button input, and a watchdog that watches a kick input. The block runs from a free-running reference clock. The watchdog timeout, the recovery stretch and the manual debounce window are parameters counted in clock cycles.

The kick, manual and supply inputs are asynchronous and pass through two-flop synchronisers. The manual input is also debounced. The watchdog restarts on every change of level of the synchronised kick, in either direction. It is held at zero while the system reset is asserted. When a level cause goes away, or when the watchdog expires, the reset stays asserted for the recovery time and then releases. A new cause that arrives during the recovery stretch starts the stretch over from the beginning.

Top module: `reset_supervisor`

## Requirements
- R1: `sys_rst_no` is always the logical complement of `sys_rst_o`.
- R2: While `rst_ni` is low, `sys_rst_o` is 1. Suppose `rst_ni` rises with `supply_ok_i`=1 and `man_rst_ni`=1. Then `sys_rst_o` falls exactly RECOVER_CYC+2 cycles later.
- R3: While `supply_ok_i` is 0, `sys_rst_o` stays 1. `sys_rst_o` falls exactly RECOVER_CYC+2 cycles after `supply_ok_i` returns to 1.
- R4: If `man_rst_ni` is held low for at least DEBOUNCE_CYC cycles, `sys_rst_o` stays 1. It falls exactly RECOVER_CYC+DEBOUNCE_CYC+2 cycles after `man_rst_ni` returns high.
- R5: A low pulse on `man_rst_ni` shorter than DEBOUNCE_CYC cycles leaves `sys_rst_o` at 0.
- R6: If the kick level does not change, the watchdog expires. `sys_rst_o` then rises exactly TIMEOUT_CYC cycles after it fell.
- R7: Each rising or falling change of `kick_i` restarts the watchdog. Changes spaced less than TIMEOUT_CYC apart keep `sys_rst_o` at 0. `sys_rst_o` rises exactly TIMEOUT_CYC+3 cycles after the last change.
- R8: A watchdog expiry produces a `sys_rst_o` pulse of exactly RECOVER_CYC cycles.
- R9: The watchdog counter is held at zero while `sys_rst_o` is 1. After a manual reset longer than TIMEOUT_CYC, the next expiry comes exactly TIMEOUT_CYC cycles after release.
- R10: A cause that occurs during the recovery stretch restarts it. After a one-cycle supply dropout in mid-stretch, release comes RECOVER_CYC+2 cycles after the supply returns.
- R11: A kick change that reaches the watchdog in the same cycle as its final count cancels the expiry. A kick change one cycle later does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Supply-good status, 1 = good (asynchronous) |
| man_rst_ni | input | 1 | Manual reset button, active low (asynchronous) |
| kick_i | input | 1 | Watchdog kick, any level change restarts (asynchronous) |
| sys_rst_o | output | 1 | Stretched system reset, active high |
| sys_rst_no | output | 1 | Stretched system reset, active low |

## Verification
Two of the block's functions can meet in one cycle: a kick edge can reach the watchdog in the very cycle its count reaches its limit. The bench provokes this by timing a kick change from the observed fall of the reset. It places the change TIMEOUT_CYC-3 cycles after the fall, so that it lands exactly on the final count, and it also places it one cycle later. The first case must yield no reset and a fresh full timeout measured from the kick. The second must still fire on the original schedule. A supply dropout in mid-stretch is a similar collision, between a new cause and the recovery count. It is judged by the exact release cycle.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
  parameter int unsigned HOLD_CYC = 4,
  parameter bit          RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = rsup_pkg::cnt_w(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else if (d_i == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      filt_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = filt_q;
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int unsigned TIMEOUT_CYC = 64,
  localparam int unsigned CW = rsup_pkg::cnt_w(TIMEOUT_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic          clear_i,
  output logic          edge_o,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  assign edge_o   = kick_i ^ prev_q;
  // an edge in the final cycle wins over expiry
  assign expire_o = (cnt_q == LAST) && !edge_o && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= kick_i;
      if (clear_i || edge_o || expire_o) cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int unsigned RECOVER_CYC = 16,
  localparam int unsigned CW = rsup_pkg::cnt_w(RECOVER_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (hold_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int unsigned TIMEOUT_CYC  = 80_000_000,
  parameter int unsigned RECOVER_CYC  = 10_000_000,
  parameter int unsigned DEBOUNCE_CYC = 500_000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic man_rst_ni,
  input  logic kick_i,
  output logic sys_rst_o,
  output logic sys_rst_no
);
  localparam int unsigned WD_W = rsup_pkg::cnt_w(TIMEOUT_CYC);
  localparam int unsigned ST_W = rsup_pkg::cnt_w(RECOVER_CYC);

  logic            supply_sync, man_sync, man_filt, kick_sync;
  logic            kick_edge, wd_expire, cause_act, rst_act;
  logic [WD_W-1:0] wd_cnt;
  logic [ST_W-1:0] stretch_cnt;

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
    .clk_i, .rst_ni, .d_i(supply_ok_i), .q_o(supply_sync));
  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_man (
    .clk_i, .rst_ni, .d_i(man_rst_ni), .q_o(man_sync));
  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_kick (
    .clk_i, .rst_ni, .d_i(kick_i), .q_o(kick_sync));

  rsup_debounce #(.HOLD_CYC(DEBOUNCE_CYC), .RST_VAL(1'b1)) u_man_db (
    .clk_i, .rst_ni, .d_i(man_sync), .q_o(man_filt));

  rsup_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk_i, .rst_ni, .kick_i(kick_sync), .clear_i(rst_act),
    .edge_o(kick_edge), .expire_o(wd_expire), .cnt_o(wd_cnt));

  assign cause_act = !supply_sync || !man_filt;

  rsup_stretch #(.RECOVER_CYC(RECOVER_CYC)) u_stretch (
    .clk_i, .rst_ni, .hold_i(cause_act || wd_expire),
    .active_o(rst_act), .cnt_o(stretch_cnt));

  assign sys_rst_o  = rst_act;
  assign sys_rst_no = ~rst_act;
endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk #(
  parameter int unsigned WD_W = 8,
  parameter int unsigned ST_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sys_rst_o,
  input logic            sys_rst_no,
  input logic            kick_edge,
  input logic            wd_expire,
  input logic            cause_act,
  input logic [WD_W-1:0] wd_cnt,
  input logic [ST_W-1:0] stretch_cnt
);
  AST_OUT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_no == !sys_rst_o); // R1
  AST_CAUSE_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_act |=> sys_rst_o); // R3
  AST_EXPIRE_STARTS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |=> sys_rst_o && stretch_cnt == '0); // R8
  AST_WD_HELD_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> wd_cnt == '0); // R9
  AST_KICK_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> wd_cnt == '0); // R7
  AST_STRETCH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_act |=> stretch_cnt == '0); // R10
  AST_EDGE_BLOCKS_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |-> !wd_expire); // R11
endmodule

bind reset_supervisor reset_supervisor_chk #(.WD_W(WD_W), .ST_W(ST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_o(sys_rst_o), .sys_rst_no(sys_rst_no),
  .kick_edge(kick_edge), .wd_expire(wd_expire), .cause_act(cause_act),
  .wd_cnt(wd_cnt), .stretch_cnt(stretch_cnt));

// File: tb/reset_supervisor_tb_top.sv
`timescale 1ns/1ps
module reset_supervisor_tb_top;
  localparam int T = 60;
  localparam int R = 10;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic man_n = 1'b1;
  logic kick = 1'b0;
  logic srst, srst_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  reset_supervisor #(.TIMEOUT_CYC(T), .RECOVER_CYC(R), .DEBOUNCE_CYC(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .man_rst_ni(man_n),
    .kick_i(kick), .sys_rst_o(srst), .sys_rst_no(srst_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles until srst differs from lvl, sampled at negedges
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (srst == lvl && n < 1000) begin
      @(negedge clk);
      n++;
      chk(srst_n == !srst, "R1", srst_n, !srst);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // known state: reset just released, watchdog fresh
  task automatic settle();
    int n;
    supply_ok = 1'b0;
    wait_n(4);
    supply_ok = 1'b1;
    run_len(1'b1, n);
  endtask

  task automatic t_power_on();
    int n;
    wait_n(3);
    chk(srst == 1'b1 && srst_n == 1'b0, "R2 reset value", srst, 1);
    rst_n = 1'b1;
    run_len(1'b1, n);
    chk(n == R + 2, "R2 power-on release", n, R + 2);
  endtask

  task automatic t_supply();
    int n;
    settle();
    supply_ok = 1'b0;
    wait_n(20);
    chk(srst == 1'b1, "R3 held", srst, 1);
    supply_ok = 1'b1;
    run_len(1'b1, n);
    chk(n == R + 2, "R3 release", n, R + 2);
  endtask

  task automatic t_manual();
    int n;
    settle();
    man_n = 1'b0;
    wait_n(20);
    chk(srst == 1'b1, "R4 held", srst, 1);
    man_n = 1'b1;
    run_len(1'b1, n);
    chk(n == R + D + 2, "R4 release", n, R + D + 2);
  endtask

  task automatic t_glitch();
    int hi = 0;
    settle();
    man_n = 1'b0;
    wait_n(D - 1);
    man_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (srst) hi++;
    end
    chk(hi == 0, "R5 short pulse ignored", hi, 0);
  endtask

  task automatic t_timeout();
    int n;
    settle();
    run_len(1'b0, n);
    chk(n == T, "R6 timeout", n, T);
    run_len(1'b1, n);
    chk(n == R, "R8 pulse width", n, R);
    run_len(1'b0, n);
    chk(n == T, "R6 repeat timeout", n, T);
    run_len(1'b1, n);
    chk(n == R, "R8 repeat pulse width", n, R);
  endtask

  task automatic t_kick();
    int n, hi = 0;
    settle();
    for (int k = 0; k < 10; k++) begin
      wait_n(T / 3);
      kick = ~kick;
      if (srst) hi++;
    end
    chk(hi == 0, "R7 kicks hold off reset", hi, 0);
    run_len(1'b0, n);
    chk(n == T + 3, "R7 after last kick", n, T + 3);
  endtask

  task automatic t_wd_hold();
    int n;
    settle();
    man_n = 1'b0;
    wait_n(3 * T);
    man_n = 1'b1;
    run_len(1'b1, n);
    chk(n == R + D + 2, "R9 release", n, R + D + 2);
    run_len(1'b0, n);
    chk(n == T, "R9 full timeout after long reset", n, T);
  endtask

  task automatic t_restart();
    int n;
    settle();
    supply_ok = 1'b0;
    wait_n(6);
    supply_ok = 1'b1;
    wait_n(5);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    run_len(1'b1, n);
    chk(n == R + 2, "R10 stretch restarted", n, R + 2);
  endtask

  task automatic t_race();
    int n;
    settle();
    wait_n(T - 3);
    kick = ~kick;
    run_len(1'b0, n);
    chk(n == T + 3, "R11 edge on final count wins", n, T + 3);
    settle();
    wait_n(T - 2);
    kick = ~kick;
    run_len(1'b0, n);
    chk(n == 2, "R11 late edge does not cancel", n, 2);
  endtask

  initial begin
    t_power_on();
    t_supply();
    t_manual();
    t_glitch();
    t_timeout();
    t_kick();
    t_wd_hold();
    t_restart();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule